// File: doc/BRIEF.md
# Expansion DMA Host Register Bank

This block is the register file that a host processor uses to program a RAM-expansion DMA controller. It holds sixteen byte-wide locations on a plain synchronous bus with a 4-bit index, write data, a write enable and a read enable. Ten of the locations hold transfer settings. These are a command byte, a 16-bit host-side address, a 24-bit expansion-side address, a 16-bit length and two control bytes. The bank presents all of them to the transfer engine as wide output words. One location is a status byte. The remaining five are unconnected.

A transfer is launched from the command byte. Writing it with both the execute bit (7) and the immediate bit (4) set starts the engine at once. Writing it with execute set and immediate clear leaves the bank armed, and the engine starts only when a separate host trigger strobe arrives. The engine reports completion and compare mismatches back as single-cycle events. These set sticky status flags, which clear when the host reads the status byte. Read data is combinational from the index. A status read returns the flags as they were before the clear.

The bank treats itself as busy from the cycle after a start until the engine reports completion, and also whenever the engine's busy input is high. While busy it accepts no writes and no triggers. Reads stay open, including the clearing status read.

Top module: `xreg_bank`

## Requirements
- R1: After reset, registers 1 to 10 hold 0x00. The status byte holds 0x40 when the MEM_KIB parameter is 128 or less, and 0x50 when it is larger (bit 4 reports the large memory).
- R2: Writes to index 0 (status) and to indices 11 to 15 have no effect. Indices 11 to 15 always read 0xFF.
- R3: Index 6 reads with bits 7..3 forced to 1. Index 9 reads with bits 4..0 forced to 1. Index 10 reads with bits 5..0 forced to 1. The stored bytes and the output ports keep the written values.
- R4: A read of index 0 with busRe high returns the current status. At that clock edge, status bits 7, 6 and 5 clear and bits 4..0 are kept.
- R5: A write of the command byte (index 1) with bits 7 and 4 both set, while not busy, gives a one-cycle startPulse in the following cycle.
- R6: When the command byte has bit 7 set and bit 4 clear, a trigStrobe while not busy, and not in a cycle that writes the command byte, gives a one-cycle startPulse in the following cycle. A trigStrobe at any other time is ignored.
- R7: An engDone event sets status bit 6 and clears command bit 7 at the next edge. This takes priority over a status read-clear and over a command write in the same cycle.
- R8: An engMismatch event sets status bit 5 at the next edge, with priority over a status read-clear in the same cycle.
- R9: The bank is busy while engBusy is high, or from the cycle after a start until the edge that takes engDone. Writes to indices 1 to 10 are ignored while busy.
- R10: Indices 1 to 10 read back the last accepted write. cmdReg is byte 1, hostAddr is {byte 3, byte 2}, expAddr is {byte 6, byte 5, byte 4}, xferLen is {byte 8, byte 7}, ctlA is byte 9 and ctlB is byte 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busAddr | input | 4 | Register index |
| busWrData | input | 8 | Write data |
| busWe | input | 1 | Write enable |
| busRe | input | 1 | Read enable (qualifies the status clear) |
| busRdData | output | 8 | Combinational read data for busAddr |
| trigStrobe | input | 1 | Host trigger for an armed transfer |
| engBusy | input | 1 | Engine reports a transfer in progress |
| engDone | input | 1 | Engine completion event |
| engMismatch | input | 1 | Engine compare-mismatch event |
| startPulse | output | 1 | One-cycle start request to the engine |
| cmdReg | output | 8 | Command byte |
| hostAddr | output | 16 | Host-side start address |
| expAddr | output | 24 | Expansion-side start address |
| xferLen | output | 16 | Transfer length |
| ctlA | output | 8 | Control byte at index 9 |
| ctlB | output | 8 | Control byte at index 10 |

## Verification
The hardest situations to reach are collisions in a single cycle. One is a status read in the same cycle as a completion or mismatch event. Another is a trigger in the same cycle as a command write, or a trigger that arrives while a launched transfer has not yet reported completion. Random stimulus with a fixed seed drives the write, read, trigger, busy, done and mismatch inputs independently. One command write in four is biased toward the immediate-start and armed patterns, so these overlaps happen often. Directed sequences then force each collision once, in a known state.

// File: rtl/xreg_pkg.sv
package xreg_pkg;
  localparam int BYTE_W    = 8;
  localparam int NUM_REGS  = 16;
  localparam int IDX_W     = $clog2(NUM_REGS);
  localparam int STAT_IDX  = 0;
  localparam int CMD_IDX   = 1;
  localparam int LAST_LIVE = 10;

  // command bit positions
  localparam int CMD_EXEC_BIT = 7;
  localparam int CMD_IMM_BIT  = 4;
  // status bit positions
  localparam int ST_EVT_BIT  = 7;
  localparam int ST_DONE_BIT = 6;
  localparam int ST_MISS_BIT = 5;
  localparam int ST_SIZE_BIT = 4;

  // read-side forced-ones masks
  localparam logic [BYTE_W-1:0] MASK_IDX6  = 8'hF8;
  localparam logic [BYTE_W-1:0] MASK_IDX9  = 8'h1F;
  localparam logic [BYTE_W-1:0] MASK_IDX10 = 8'h3F;

  typedef struct packed {
    logic              wrEn;
    logic [IDX_W-1:0]  wrIdx;
    logic [BYTE_W-1:0] wrData;
    logic              rdClr;
    logic              setDone;
    logic              setMiss;
  } ctlStrobe_t;
endpackage

// File: rtl/xreg_ctrl.sv
module xreg_ctrl
  import xreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  busAddr,
  input  logic [BYTE_W-1:0] busWrData,
  input  logic              busWe,
  input  logic              busRe,
  input  logic              trigStrobe,
  input  logic              engBusy,
  input  logic              engDone,
  input  logic              engMismatch,
  input  logic [BYTE_W-1:0] cmdNow,
  output ctlStrobe_t        strobes,
  output logic              startPulse,
  output logic              busyNow
);
  logic launchedQ;
  logic startPulseQ;
  logic liveIdx, wrOk, cmdWr, immStart, armed, trigStart, startNow;

  assign busyNow  = engBusy | launchedQ;
  assign liveIdx  = (busAddr >= IDX_W'(CMD_IDX)) && (busAddr <= IDX_W'(LAST_LIVE));
  assign wrOk     = busWe && liveIdx && !busyNow;
  assign cmdWr    = wrOk && (busAddr == IDX_W'(CMD_IDX));
  assign immStart = cmdWr && busWrData[CMD_EXEC_BIT] && busWrData[CMD_IMM_BIT];
  assign armed    = cmdNow[CMD_EXEC_BIT] && !cmdNow[CMD_IMM_BIT];
  assign trigStart = trigStrobe && armed && !busyNow && !cmdWr;
  assign startNow = immStart || trigStart;

  always_comb begin
    strobes.wrEn    = wrOk;
    strobes.wrIdx   = busAddr;
    strobes.wrData  = busWrData;
    strobes.rdClr   = busRe && (busAddr == IDX_W'(STAT_IDX));
    strobes.setDone = engDone;
    strobes.setMiss = engMismatch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      launchedQ   <= 1'b0;
      startPulseQ <= 1'b0;
    end else begin
      startPulseQ <= startNow;
      if (startNow)     launchedQ <= 1'b1;
      else if (engDone) launchedQ <= 1'b0;
    end
  end

  assign startPulse = startPulseQ;
endmodule

// File: rtl/xreg_dp.sv
module xreg_dp
  import xreg_pkg::*;
#(
  parameter int MEM_KIB   = 512,
  parameter int SMALL_KIB = 128
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  ctlStrobe_t                     strobes,
  input  logic [IDX_W-1:0]               rdIdx,
  output logic [BYTE_W-1:0]              rdData,
  output logic [BYTE_W-1:0]              statusQ,
  output logic [LAST_LIVE:1][BYTE_W-1:0] liveBytes
);
  localparam logic SIZE_FLAG = (MEM_KIB > SMALL_KIB);
  localparam logic [BYTE_W-1:0] STAT_RESET =
    BYTE_W'(1 << ST_DONE_BIT) | (SIZE_FLAG ? BYTE_W'(1 << ST_SIZE_BIT) : '0);

  logic [LAST_LIVE:1][BYTE_W-1:0] liveQ;
  logic [BYTE_W-1:0] statusNext;

  // status: read-clear first, events override
  always_comb begin
    statusNext = statusQ;
    if (strobes.rdClr) begin
      statusNext[ST_EVT_BIT]  = 1'b0;
      statusNext[ST_DONE_BIT] = 1'b0;
      statusNext[ST_MISS_BIT] = 1'b0;
    end
    if (strobes.setMiss) statusNext[ST_MISS_BIT] = 1'b1;
    if (strobes.setDone) statusNext[ST_DONE_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) statusQ <= STAT_RESET;
    else        statusQ <= statusNext;
  end

  for (genvar g = 1; g <= LAST_LIVE; g++) begin : g_live
    if (g == CMD_IDX) begin : g_cmd
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) liveQ[g] <= '0;
        else begin
          if (strobes.wrEn && strobes.wrIdx == IDX_W'(g)) liveQ[g] <= strobes.wrData;
          if (strobes.setDone) liveQ[g][CMD_EXEC_BIT] <= 1'b0;
        end
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) liveQ[g] <= '0;
        else if (strobes.wrEn && strobes.wrIdx == IDX_W'(g)) liveQ[g] <= strobes.wrData;
      end
    end
  end

  always_comb begin
    if (rdIdx == IDX_W'(STAT_IDX))       rdData = statusQ;
    else if (rdIdx > IDX_W'(LAST_LIVE))  rdData = '1;
    else if (rdIdx == IDX_W'(6))         rdData = liveQ[6] | MASK_IDX6;
    else if (rdIdx == IDX_W'(9))         rdData = liveQ[9] | MASK_IDX9;
    else if (rdIdx == IDX_W'(10))        rdData = liveQ[10] | MASK_IDX10;
    else                                 rdData = liveQ[rdIdx];
  end

  assign liveBytes = liveQ;
endmodule

// File: rtl/xreg_bank.sv
module xreg_bank
  import xreg_pkg::*;
#(
  parameter int MEM_KIB   = 512,
  parameter int SMALL_KIB = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  busAddr,
  input  logic [7:0]  busWrData,
  input  logic        busWe,
  input  logic        busRe,
  output logic [7:0]  busRdData,
  input  logic        trigStrobe,
  input  logic        engBusy,
  input  logic        engDone,
  input  logic        engMismatch,
  output logic        startPulse,
  output logic [7:0]  cmdReg,
  output logic [15:0] hostAddr,
  output logic [23:0] expAddr,
  output logic [15:0] xferLen,
  output logic [7:0]  ctlA,
  output logic [7:0]  ctlB
);
  ctlStrobe_t strobes;
  logic busyNow;
  logic [BYTE_W-1:0] statusQ;
  logic [LAST_LIVE:1][BYTE_W-1:0] liveBytes;

  xreg_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrData(busWrData),
    .busWe(busWe), .busRe(busRe), .trigStrobe(trigStrobe), .engBusy(engBusy),
    .engDone(engDone), .engMismatch(engMismatch), .cmdNow(liveBytes[CMD_IDX]),
    .strobes(strobes), .startPulse(startPulse), .busyNow(busyNow)
  );

  xreg_dp #(.MEM_KIB(MEM_KIB), .SMALL_KIB(SMALL_KIB)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .rdIdx(busAddr),
    .rdData(busRdData), .statusQ(statusQ), .liveBytes(liveBytes)
  );

  assign cmdReg   = liveBytes[1];
  assign hostAddr = {liveBytes[3], liveBytes[2]};
  assign expAddr  = {liveBytes[6], liveBytes[5], liveBytes[4]};
  assign xferLen  = {liveBytes[8], liveBytes[7]};
  assign ctlA     = liveBytes[9];
  assign ctlB     = liveBytes[10];
endmodule

// File: rtl/xreg_bank_chk.sv
module xreg_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  busAddr,
  input logic [7:0]  busWrData,
  input logic        busWe,
  input logic [7:0]  busRdData,
  input logic        trigStrobe,
  input logic        engDone,
  input logic        engMismatch,
  input logic        startPulse,
  input logic [7:0]  cmdReg,
  input logic [15:0] hostAddr,
  input logic        busyNow,
  input logic [7:0]  statusQ
);
  a_r2_unconn_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (busAddr > 4'd10) |-> (busRdData == 8'hFF));

  a_r5_imm_start: assert property (@(posedge clk) disable iff (!rst_n)
    (busWe && !busyNow && busAddr == 4'd1 && busWrData[7] && busWrData[4]) |=> startPulse);

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    startPulse |=> !startPulse);

  a_r6_unarmed_trig: assert property (@(posedge clk) disable iff (!rst_n)
    (trigStrobe && !busWe && !cmdReg[7]) |=> !startPulse);

  a_r7_done_flag: assert property (@(posedge clk) disable iff (!rst_n)
    engDone |=> statusQ[6]);

  a_r7_done_clears_exec: assert property (@(posedge clk) disable iff (!rst_n)
    engDone |=> !cmdReg[7]);

  a_r8_miss_flag: assert property (@(posedge clk) disable iff (!rst_n)
    engMismatch |=> statusQ[5]);

  a_r9_busy_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    (busyNow && busWe && busAddr == 4'd2) |=> $stable(hostAddr[7:0]));
endmodule

bind xreg_bank xreg_bank_chk u_chk (.*);

// File: tb/xreg_bank_tb.sv
`timescale 1ns/1ps
module xreg_bank_tb;
  localparam int MEM_KIB = 512;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic [3:0] busAddr = 0;
  logic [7:0] busWrData = 0;
  logic busWe = 0, busRe = 0, trigStrobe = 0, engBusy = 0, engDone = 0, engMismatch = 0;
  logic [7:0] busRdData, cmdReg, ctlA, ctlB;
  logic [15:0] hostAddr, xferLen;
  logic [23:0] expAddr;
  logic startPulse;

  xreg_bank #(.MEM_KIB(MEM_KIB)) u_dut (.*);

  int nChk = 0, nFail = 0;
  bit finished = 0;
  logic [7:0] m [0:15];
  logic mLaunched, mStart;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mRead(int a);
    if (a == 0) return m[0];
    if (a >= 11) return 8'hFF;
    if (a == 6) return m[6] | 8'hF8;
    if (a == 9) return m[9] | 8'h1F;
    if (a == 10) return m[10] | 8'h3F;
    return m[a];
  endfunction

  function automatic string rdTag(int a);
    if (a == 0) return "R4 status read";
    if (a >= 11) return "R2 unconnected";
    if (a == 6 || a == 9 || a == 10) return "R3 masked read";
    return "R10 readback";
  endfunction

  task automatic modelReset();
    m[0] = 8'h40 | ((MEM_KIB > 128) ? 8'h10 : 8'h00);
    for (int i = 1; i < 16; i++) m[i] = 8'h00;
    mLaunched = 0; mStart = 0;
  endtask

  task automatic cyc(bit we, bit re, int a, logic [7:0] wd, bit trig, bit eb, bit dn, bit ms);
    bit busy, wrOk, cmdWr, imm, armed, trg, st;
    @(negedge clk);
    busWe = we; busRe = re; busAddr = 4'(a); busWrData = wd;
    trigStrobe = trig; engBusy = eb; engDone = dn; engMismatch = ms;
    #1;
    if (re) chk(rdTag(a), busRdData, mRead(a));
    chk("R5 R6 startPulse", startPulse, mStart);
    chk("R10 cmdReg", cmdReg, m[1]);
    chk("R10 hostAddr", hostAddr, {m[3], m[2]});
    chk("R10 expAddr", expAddr, {m[6], m[5], m[4]});
    chk("R10 xferLen", xferLen, {m[8], m[7]});
    chk("R10 ctl", {ctlA, ctlB}, {m[9], m[10]});
    busy  = eb || mLaunched;
    wrOk  = we && a >= 1 && a <= 10 && !busy;
    cmdWr = wrOk && a == 1;
    imm   = cmdWr && wd[7] && wd[4];
    armed = m[1][7] && !m[1][4];
    trg   = trig && armed && !busy && !cmdWr;
    st    = imm || trg;
    if (re && a == 0) m[0] = m[0] & 8'h1F;
    if (ms) m[0][5] = 1'b1;
    if (dn) m[0][6] = 1'b1;
    if (wrOk) m[a] = wd;
    if (dn) m[1][7] = 1'b0;
    if (st) mLaunched = 1; else if (dn) mLaunched = 0;
    mStart = st;
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1: reset values of every location
    for (int i = 0; i < 16; i++) cyc(0, 1, i, 0, 0, 0, 0, 0);
    // R2: writes to status and unconnected slots ignored
    cyc(1, 0, 0, 8'hFF, 0, 0, 0, 0);
    cyc(1, 0, 12, 8'h00, 0, 0, 0, 0);
    cyc(0, 1, 0, 0, 0, 0, 0, 0);
    cyc(0, 1, 12, 0, 0, 0, 0, 0);
    // R3: masked reads keep stored bytes
    cyc(1, 0, 6, 8'h05, 0, 0, 0, 0);
    cyc(1, 0, 9, 8'hA0, 0, 0, 0, 0);
    cyc(1, 0, 10, 8'h40, 0, 0, 0, 0);
    cyc(0, 1, 6, 0, 0, 0, 0, 0);
    cyc(0, 1, 9, 0, 0, 0, 0, 0);
    cyc(0, 1, 10, 0, 0, 0, 0, 0);
    // R6: trigger while unarmed ignored
    cyc(0, 0, 0, 0, 1, 0, 0, 0);
    idle();
    // R6: arm, then trigger collides with a command write (ignored), then trigger alone
    cyc(1, 0, 1, 8'h80, 0, 0, 0, 0);
    cyc(1, 0, 1, 8'h80, 1, 0, 0, 0);
    idle();
    cyc(0, 0, 0, 0, 1, 0, 0, 0);
    // R9: launched, so trigger and writes ignored until done
    cyc(0, 0, 0, 0, 1, 0, 0, 0);
    cyc(1, 0, 2, 8'h77, 0, 0, 0, 0);
    cyc(0, 1, 2, 0, 0, 0, 0, 0);
    // R7 R4: done in the same cycle as a status read-clear
    cyc(0, 1, 0, 0, 0, 0, 1, 0);
    cyc(0, 1, 0, 0, 0, 0, 0, 0);
    cyc(0, 1, 0, 0, 0, 0, 0, 0);
    // R8: mismatch with a read-clear
    cyc(0, 1, 0, 0, 0, 0, 0, 1);
    cyc(0, 1, 0, 0, 0, 0, 0, 0);
    // R5: immediate start, then done
    cyc(1, 0, 1, 8'h91, 0, 0, 0, 0);
    idle();
    cyc(0, 0, 0, 0, 0, 1, 1, 0);
    // R9: engBusy blocks writes
    cyc(1, 0, 3, 8'h12, 0, 1, 0, 0);
    cyc(0, 1, 3, 0, 0, 0, 0, 0);
    // random mix
    for (int n = 0; n < 4000; n++) begin
      int a;
      logic [7:0] wd;
      a  = int'($urandom_range(0, 15));
      wd = 8'($urandom);
      if ($urandom_range(0, 3) == 0) begin
        a = 1;
        case ($urandom_range(0, 3))
          0: wd = 8'h90;
          1: wd = 8'h80;
          2: wd = 8'h00;
          default: ;
        endcase
      end
      cyc($urandom_range(0, 9) < 4, $urandom_range(0, 1) == 1, a, wd,
          $urandom_range(0, 4) == 0, $urandom_range(0, 4) == 0,
          $urandom_range(0, 9) == 0, $urandom_range(0, 9) == 0);
    end
    idle();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end
endmodule